// File: doc/BRIEF.md
# Three-Wire Control Word Writer

This block sends 16-bit control words to a codec over a write-only three-wire port. The port has a serial data line, a shift clock and an active-low latch strobe. A host asks for a write on a valid/ready channel, giving a 2-bit register number and a 9-bit setting. The block places the register number in bits 10:9 of the word and the setting in bits 8:0. It then shifts the 16 bits out, most significant bit first, and pulses the latch strobe low to commit the word.

The shift clock comes from the system clock through a programmable divider. This lets the port run slowly enough to meet the codec's setup and hold times. The divider value is taken only while the block is idle, so a change during a transfer cannot disturb it.

After reset, a startup sequencer writes four default configuration words. The block accepts no host request until the sequencer finishes. The channel has no buffering. `req_ready` is high only when the port is idle and startup is complete. A request that is offered while `req_ready` is low is neither stored nor sent, so the host must hold `req_valid` until a cycle in which `req_ready` is high.

Top module: `cw3_writer`

## Requirements
- R1: A written word has bits 15:11 zero, the register number in bits 10:9 and the setting in bits 8:0.
- R2: The word leaves on `cw_sdo` most significant bit first, one bit per rising edge of `cw_sck`. `cw_sdo` changes only while `cw_sck` is low.
- R3: Every half period of `cw_sck` lasts `div_cfg`+1 system clocks, using the `div_cfg` value held at the edge that accepts the word. Changing `div_cfg` during a transfer has no effect on that transfer.
- R4: While no transfer is active, `cw_sck` is low and `cw_latch_n` is high.
- R5: `cw_latch_n` stays high while bits shift. After the 16th bit, it goes low for exactly one shift-clock period (2×(`div_cfg`+1) system clocks) and then returns high. `cw_sck` stays low during that pulse.
- R6: A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only when the block is idle and `boot_done` is set. A request offered while `req_ready` is low is discarded.
- R7: `busy` rises in the cycle after a word is accepted. It stays high for exactly 34×(`div_cfg`+1) system clocks and falls when the latch strobe returns high.
- R8: The startup sequencer accepts its first word at the first clock edge after reset is released. It writes 0x00FF, 0x02FF, 0x0442 and 0x060C, in that order, each at the same timing as a host word.
- R9: `boot_done` is low during reset and during startup. It rises the cycle after the fourth startup word ends and then stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_cfg | input | DIV_W | Half-period of the shift clock, in system clocks, minus one |
| req_valid | input | 1 | Host write request is valid |
| req_ready | output | 1 | Block can accept a host write |
| req_index | input | 2 | Register number to write |
| req_data | input | 9 | Register setting |
| busy | output | 1 | A transfer is in progress |
| boot_done | output | 1 | The startup configuration has been written |
| cw_sck | output | 1 | Serial shift clock |
| cw_sdo | output | 1 | Serial data, MSB first |
| cw_latch_n | output | 1 | Latch strobe, low pulse commits a word |

## Verification
The assertions check, on every cycle, that the idle shift clock is low and that data never moves while the shift clock is high. They also check that the latch strobe is high whenever the shift clock is high, that the strobe goes low only inside a transfer, that `req_ready` never overlaps `busy` or precedes `boot_done`, and that `boot_done` never falls. The content and order of the words, the bit order, the exact lengths of the clock half periods, the strobe and `busy`, and the way a divider change or a rejected request fails to reach the port can only be shown by the bench. The bench does this by decoding the serial line in its scenarios.

// File: rtl/cw3_pkg.sv
package cw3_pkg;
  localparam int WORD_W  = 16;
  localparam int IDX_W   = 2;
  localparam int DAT_W   = 9;
  localparam int IDX_LSB = DAT_W;
  localparam int PAD_W   = WORD_W - IDX_W - DAT_W;
  localparam int BOOT_N  = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LATCH = 2'd2
  } cw_state_e;

  function automatic logic [WORD_W-1:0] pack_word(input logic [IDX_W-1:0] idx,
                                                  input logic [DAT_W-1:0] dat);
    return {{PAD_W{1'b0}}, idx, dat};
  endfunction

  // Default settings replayed after reset, one per register number
  function automatic logic [DAT_W-1:0] boot_setting(input logic [IDX_W-1:0] idx);
    logic [DAT_W-1:0] s;
    case (idx)
      2'd0:    s = 9'h0FF;
      2'd1:    s = 9'h0FF;
      2'd2:    s = 9'h042;
      default: s = 9'h00C;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/cw3_divider.sv
module cw3_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load) div_q <= div_cfg;
      if (!run || cnt_q == div_q) cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == div_q);
endmodule

// File: rtl/cw3_shifter.sv
module cw3_shifter
  import cw3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic              tick,
  output logic              idle,
  output logic              sck,
  output logic              sdo,
  output logic              latch_n
);
  localparam int CNT_W = $clog2(WORD_W);

  cw_state_e         state_q;
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  bit_q;
  logic              half_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      bit_q   <= '0;
      half_q  <= 1'b0;
      sck     <= 1'b0;
      sdo     <= 1'b0;
      latch_n <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          sck     <= 1'b0;
          latch_n <= 1'b1;
          if (start) begin
            sh_q    <= {word[WORD_W-2:0], 1'b0};
            sdo     <= word[WORD_W-1];
            bit_q   <= '0;
            half_q  <= 1'b0;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: if (tick) begin
          if (!half_q) begin
            sck    <= 1'b1;
            half_q <= 1'b1;
          end else begin
            sck    <= 1'b0;
            half_q <= 1'b0;
            if (bit_q == CNT_W'(WORD_W-1)) begin
              latch_n <= 1'b0;
              state_q <= ST_LATCH;
            end else begin
              sdo   <= sh_q[WORD_W-1];
              sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_LATCH: if (tick) begin
          if (!half_q) begin
            half_q <= 1'b1;
          end else begin
            half_q  <= 1'b0;
            latch_n <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle = (state_q == ST_IDLE);
endmodule

// File: rtl/cw3_boot.sv
module cw3_boot
  import cw3_pkg::*;
#(
  parameter bit BOOT_ENABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  output logic              boot_valid,
  output logic [WORD_W-1:0] boot_word,
  output logic              boot_done
);
  localparam int PTR_W = $clog2(BOOT_N + 1);

  generate
    if (BOOT_ENABLE) begin : g_seq
      logic [PTR_W-1:0] ptr_q;
      logic             done_q;
      logic             more;

      assign more       = (ptr_q < PTR_W'(BOOT_N));
      assign boot_valid = !done_q && more && idle;
      assign boot_word  = pack_word(ptr_q[IDX_W-1:0], boot_setting(ptr_q[IDX_W-1:0]));
      assign boot_done  = done_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ptr_q  <= '0;
          done_q <= 1'b0;
        end else begin
          if (boot_valid) ptr_q <= ptr_q + 1'b1;
          if (!more && idle) done_q <= 1'b1;
        end
      end
    end else begin : g_none
      assign boot_valid = 1'b0;
      assign boot_word  = '0;
      assign boot_done  = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/cw3_writer.sv
module cw3_writer
  import cw3_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter bit BOOT_ENABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_index,
  input  logic [8:0]       req_data,
  output logic             busy,
  output logic             boot_done,
  output logic             cw_sck,
  output logic             cw_sdo,
  output logic             cw_latch_n
);
  logic              idle;
  logic              tick;
  logic              boot_valid;
  logic [WORD_W-1:0] boot_word;
  logic              host_fire;
  logic              start;
  logic [WORD_W-1:0] start_word;

  cw3_boot #(.BOOT_ENABLE(BOOT_ENABLE)) i_boot (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle       (idle),
    .boot_valid (boot_valid),
    .boot_word  (boot_word),
    .boot_done  (boot_done)
  );

  assign req_ready  = idle && boot_done;
  assign host_fire  = req_valid && req_ready;
  assign start      = boot_valid || host_fire;
  assign start_word = boot_valid ? boot_word : pack_word(req_index, req_data);

  cw3_divider #(.DIV_W(DIV_W)) i_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (idle),
    .run     (!idle),
    .div_cfg (div_cfg),
    .tick    (tick)
  );

  cw3_shifter i_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .word    (start_word),
    .tick    (tick),
    .idle    (idle),
    .sck     (cw_sck),
    .sdo     (cw_sdo),
    .latch_n (cw_latch_n)
  );

  assign busy = !idle;
endmodule

// File: rtl/cw3_checker.sv
module cw3_checker (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic busy,
  input logic boot_done,
  input logic cw_sck,
  input logic cw_sdo,
  input logic cw_latch_n
);
  AST_SCK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cw_sck); // R4
  AST_SDO_HOLD_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cw_sck |-> $stable(cw_sdo)); // R2
  AST_LATCH_HIGH_WITH_SCK: assert property (@(posedge clk) disable iff (!rst_n)
    cw_sck |-> cw_latch_n); // R5
  AST_LATCH_LOW_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    !cw_latch_n |-> busy); // R5
  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R6
  AST_READY_AFTER_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> boot_done); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done); // R9
endmodule

bind cw3_writer cw3_checker i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .busy       (busy),
  .boot_done  (boot_done),
  .cw_sck     (cw_sck),
  .cw_sdo     (cw_sdo),
  .cw_latch_n (cw_latch_n)
);

// File: tb/test_cw3_writer.sv
module test_cw3_writer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_cfg = 8'd3;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_index = '0;
  logic [8:0] req_data = '0;
  logic       busy, boot_done, cw_sck, cw_sdo, cw_latch_n;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cw3_writer i_cw3_writer (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .req_data(req_data),
    .busy(busy), .boot_done(boot_done),
    .cw_sck(cw_sck), .cw_sdo(cw_sdo), .cw_latch_n(cw_latch_n)
  );

  // Serial line decoder
  logic [15:0] words [0:31];
  int          wcnt = 0;
  logic [15:0] cap = '0;
  int          nbits = 0, bits_at_latch = 0;
  int          hi_run = 0, hi_len = 0, lo_run = 0, lat_len = 0;
  int          sck_lat_viol = 0, sdo_viol = 0;
  logic        sck_p = 1'b0, lat_p = 1'b1, sdo_p = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cw_sck && !sck_p) begin
        cap = {cap[14:0], cw_sdo};
        nbits++;
      end
      if (cw_sck) hi_run++;
      else if (sck_p) begin
        hi_len = hi_run;
        hi_run = 0;
      end
      if (cw_sck && sck_p && cw_sdo != sdo_p) sdo_viol++;
      if (!cw_latch_n && cw_sck) sck_lat_viol++;
      if (!cw_latch_n) lo_run++;
      if (!cw_latch_n && lat_p) bits_at_latch = nbits;
      if (cw_latch_n && !lat_p) begin
        lat_len = lo_run;
        lo_run = 0;
        if (wcnt < 32) words[wcnt] = cap;
        wcnt++;
        nbits = 0;
      end
    end
    sck_p = cw_sck;
    lat_p = cw_latch_n;
    sdo_p = cw_sdo;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] i, input logic [8:0] d, output int busy_cycles);
    while (!req_ready) @(negedge clk);
    req_index = i; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy_cycles = 0;
    while (busy) begin
      busy_cycles++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!cw_sck, "R4 sck in reset", int'(cw_sck), 0);
    chk(cw_latch_n, "R4 latch in reset", int'(cw_latch_n), 1);
    chk(!boot_done, "R9 done in reset", int'(boot_done), 0);
    chk(!req_ready, "R6 ready in reset", int'(req_ready), 0);
  endtask

  task automatic t_boot;
    logic [15:0] exp [0:3];
    int early;
    exp[0] = 16'h00FF; exp[1] = 16'h02FF; exp[2] = 16'h0442; exp[3] = 16'h060C;
    early = 0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy, "R8 first boot word accepted at first edge", int'(busy), 1);
    while (!boot_done) begin
      if (req_ready) early++;
      @(negedge clk);
    end
    chk(early == 0, "R9 ready before boot done", early, 0);
    chk(!busy, "R9 done after last word ends", int'(busy), 0);
    chk(wcnt == 4, "R8 boot word count", wcnt, 4);
    for (int k = 0; k < 4; k++)
      chk(words[k] == exp[k], "R8 boot word", int'(words[k]), int'(exp[k]));
    @(negedge clk);
    chk(req_ready, "R6 ready once idle and done", int'(req_ready), 1);
  endtask

  task automatic t_patterns;
    logic [1:0] ii [0:3];
    logic [8:0] dd [0:3];
    int bc, w0;
    ii[0] = 2'd3; dd[0] = 9'h1FF;
    ii[1] = 2'd0; dd[1] = 9'h100;
    ii[2] = 2'd2; dd[2] = 9'h0A5;
    ii[3] = 2'd1; dd[3] = 9'h001;
    div_cfg = 8'd0;
    for (int k = 0; k < 4; k++) begin
      w0 = wcnt;
      host_write(ii[k], dd[k], bc);
      chk(wcnt == w0 + 1, "R6 one word per request", wcnt - w0, 1);
      chk(words[w0] == {5'b0, ii[k], dd[k]}, "R1 R2 word bits",
          int'(words[w0]), int'({5'b0, ii[k], dd[k]}));
      chk(bits_at_latch == 16, "R5 16 bits before latch", bits_at_latch, 16);
    end
    chk(sdo_viol == 0, "R2 sdo moved with sck high", sdo_viol, 0);
    chk(sck_lat_viol == 0, "R5 sck high during latch", sck_lat_viol, 0);
    chk(!cw_sck && cw_latch_n, "R4 idle levels", {cw_sck, cw_latch_n}, 1);
  endtask

  task automatic t_timing(input logic [7:0] dv);
    int bc;
    div_cfg = dv;
    host_write(2'd2, 9'h155, bc);
    chk(hi_len == dv + 1, "R3 sck high half period", hi_len, dv + 1);
    chk(lat_len == 2 * (dv + 1), "R5 latch low length", lat_len, 2 * (dv + 1));
    chk(bc == 34 * (dv + 1), "R7 busy length", bc, 34 * (dv + 1));
  endtask

  task automatic t_div_change;
    int bc;
    div_cfg = 8'd2;
    while (!req_ready) @(negedge clk);
    req_index = 2'd1; req_data = 9'h0F0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    div_cfg = 8'd9;
    bc = 5;
    while (busy) begin
      bc++;
      @(negedge clk);
    end
    @(negedge clk);
    chk(hi_len == 3, "R3 divider held through transfer", hi_len, 3);
    chk(bc == 34 * 3, "R3 busy length with old divider", bc, 102);
    div_cfg = 8'd1;
  endtask

  task automatic t_busy_ignore;
    int w0, rdy_seen;
    w0 = wcnt;
    rdy_seen = 0;
    div_cfg = 8'd3;
    while (!req_ready) @(negedge clk);
    req_index = 2'd0; req_data = 9'h033; req_valid = 1'b1;
    @(negedge clk);
    req_index = 2'd3; req_data = 9'h1CC;
    repeat (20) begin
      if (req_ready) rdy_seen++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(rdy_seen == 0, "R6 ready low while busy", rdy_seen, 0);
    chk(wcnt == w0 + 1, "R6 request during busy dropped", wcnt - w0, 1);
    chk(words[w0] == 16'h0033, "R6 only first word sent", int'(words[w0]), 16'h0033);
    chk(!busy, "R6 no buffered transfer started", int'(busy), 0);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    t_boot();
    t_patterns();
    t_timing(8'd0);
    t_timing(8'd5);
    t_div_change();
    t_busy_ignore();
    report();
  end
endmodule